// File: doc/BRIEF.md
# DMA Descriptor Fetch and Chain Walker

This block sits in front of a DMA payload engine. It reads 16-byte transfer descriptors through a simple 32-bit read port, splits them into fields, and keeps the source and destination current-descriptor pointers up to date. Each descriptor carries a 64-bit buffer address, a 30-bit byte count and a few attribute bits. The attributes are coherency, chain type, interrupt-on-completion and a source-only command. A chain is either a contiguous array of descriptors or a linked list. In a linked list the 64-bit pointer to the next descriptor is stored in the two words that follow each descriptor.

The payload engine drives the block with three strobes. It asks for the next source descriptor, it asks for a new destination descriptor when the remaining destination count reaches zero, and it reports that the current source descriptor has been fully processed. The destination pointer moves on as soon as its descriptor is fetched. The source pointer moves only when processing is reported. In register mode no memory is touched. A fetch request then presents a descriptor taken from configuration inputs. A pointer that is not aligned to 16 bytes is trapped: the block presents a zero descriptor and raises an error.

Top module: `dma_dscr_walker`

## Requirements
- R1: After reset both pointers are zero and `desc_valid`, `err_flag` and `rd_req` are low.
- R2: A memory-mode fetch issues four 32-bit reads, in order, at pointer, +4, +8 and +12, and holds `rd_req` and `rd_addr` steady until `rd_valid` arrives. The fields are decoded as follows:
  - address: word 1 then word 0, forming 64 bits;
  - size: word 2 bits 29..0;
  - attributes in word 3: coherent at bit 0, type at bit 1 (0 = linear, 1 = linked), interrupt at bit 2, command at bits 4..3.
- R3: `desc_valid` pulses for one cycle after the last descriptor word arrives. A source fetch leaves `src_ptr` unchanged. `src_done` after a linear source descriptor adds 16 to `src_ptr`.
- R4: `src_done` after a linked source descriptor reads the words at `src_ptr`+16 and +20. `src_ptr` then becomes {second word bits 16..0, first word}.
- R5: A destination fetch of a linear descriptor adds 16 to `dst_ptr` in the same cycle that `desc_valid` rises.
- R6: A destination fetch of a linked descriptor reads two further words at +16 and +20. `dst_ptr` becomes {second word bits 16..0, first word}, and `desc_valid` rises only after that.
- R7: A destination descriptor always reports `desc_cmd` = 0, whatever word 3 bits 4..3 hold.
- R8: A fetch from a pointer with bits 3..0 not all zero issues no read. It presents an all-zero descriptor with `desc_valid`, pulses `src_err` or `dst_err` for the side concerned, and sets `err_flag`. On the destination side `dst_ptr` still advances by 16. On the source side a later `src_done` advances `src_ptr` by 16.
- R9: In register mode (`mem_mode` = 0) a fetch presents the configured descriptor on the next cycle, with no read and no pointer change. In this mode `src_done` has no effect.
- R10: `ld_ptrs` loads both 49-bit pointers from the start inputs and clears `err_flag`.
- R11: Requests that arrive while `busy` is high are dropped. When requests arrive together, a source fetch wins over a destination fetch, and a destination fetch wins over `src_done`. The losers are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_mode | input | 1 | 1: descriptors come from memory; 0: from configuration inputs |
| ld_ptrs | input | 1 | Load both pointers from the start inputs |
| src_start | input | 49 | Source chain start pointer |
| dst_start | input | 49 | Destination chain start pointer |
| fetch_src | input | 1 | Request the next source descriptor |
| fetch_dst | input | 1 | Request the next destination descriptor |
| src_done | input | 1 | Current source descriptor has been processed |
| cfg_src_addr | input | 49 | Register-mode source buffer address |
| cfg_src_size | input | 30 | Register-mode source size |
| cfg_src_attr | input | 5 | Register-mode source attributes (R2 layout) |
| cfg_dst_addr | input | 49 | Register-mode destination buffer address |
| cfg_dst_size | input | 30 | Register-mode destination size |
| cfg_dst_attr | input | 3 | Register-mode destination attributes (coherent, type, interrupt) |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | 49 | Read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| busy | output | 1 | A memory operation is in progress |
| desc_valid | output | 1 | One-cycle strobe: descriptor fields are valid |
| desc_side | output | 1 | 0: source descriptor, 1: destination descriptor |
| desc_addr | output | 64 | Buffer address |
| desc_size | output | 30 | Byte count |
| desc_coh | output | 1 | Coherent attribute |
| desc_type | output | 1 | Chain type (0 linear, 1 linked) |
| desc_intr | output | 1 | Interrupt-on-completion attribute |
| desc_cmd | output | 2 | Source command, zero for destination |
| src_err | output | 1 | Source descriptor-read error strobe |
| dst_err | output | 1 | Destination descriptor-read error strobe |
| err_flag | output | 1 | Latched error |
| src_ptr | output | 49 | Current source descriptor pointer |
| dst_ptr | output | 49 | Current destination descriptor pointer |

## Verification
The hardest case to reach is a request that arrives during the middle of a six-word linked destination walk. The same holds for a next-pointer word whose upper 15 bits are non-zero and must be discarded. The memory model in the bench answers each read after a random latency, which stretches every walk over many cycles. A directed step injects `fetch_src` and `src_done` while `busy` is high, then counts reads and valid strobes. Random next-pointer words carry random upper bits, so the 17-bit truncation is tested on every linked step.

// File: rtl/dma_dscr_walker.sv
module dma_dscr_walker #(
  parameter int AW  = 49,
  parameter int SZW = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mem_mode,
  input  logic           ld_ptrs,
  input  logic [AW-1:0]  src_start,
  input  logic [AW-1:0]  dst_start,
  input  logic           fetch_src,
  input  logic           fetch_dst,
  input  logic           src_done,
  input  logic [AW-1:0]  cfg_src_addr,
  input  logic [SZW-1:0] cfg_src_size,
  input  logic [4:0]     cfg_src_attr,
  input  logic [AW-1:0]  cfg_dst_addr,
  input  logic [SZW-1:0] cfg_dst_size,
  input  logic [2:0]     cfg_dst_attr,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_valid,
  input  logic [31:0]    rd_data,
  output logic           busy,
  output logic           desc_valid,
  output logic           desc_side,
  output logic [63:0]    desc_addr,
  output logic [SZW-1:0] desc_size,
  output logic           desc_coh,
  output logic           desc_type,
  output logic           desc_intr,
  output logic [1:0]     desc_cmd,
  output logic           src_err,
  output logic           dst_err,
  output logic           err_flag,
  output logic [AW-1:0]  src_ptr,
  output logic [AW-1:0]  dst_ptr
);
  localparam int HIW = AW - 32;
  localparam int BW  = 64 + SZW + 5;
  localparam logic [AW-1:0] STEP = AW'(16);

  logic [2:0]    wcnt;
  logic          op_dst, adv_q, src_type_q;
  logic [BW-1:0] dbuf;
  logic [31:0]   lnk_lo;

  wire pick_s = fetch_src;
  wire pick_d = fetch_dst & ~fetch_src;
  wire pick_a = src_done & ~fetch_src & ~fetch_dst & mem_mode;
  wire [AW-1:0] req_ptr   = pick_s ? src_ptr : dst_ptr;
  wire          misal     = |req_ptr[3:0];
  wire [AW-1:0] next_link = {rd_data[HIW-1:0], lnk_lo};

  assign rd_req    = busy;
  assign rd_addr   = (op_dst ? dst_ptr : src_ptr) + {{(AW-5){1'b0}}, wcnt, 2'b00};
  assign desc_addr = dbuf[63:0];
  assign desc_size = dbuf[64 +: SZW];
  assign desc_coh  = dbuf[64+SZW];
  assign desc_type = dbuf[65+SZW];
  assign desc_intr = dbuf[66+SZW];
  assign desc_cmd  = desc_side ? 2'b00 : dbuf[68+SZW -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wcnt <= '0; op_dst <= 1'b0; adv_q <= 1'b0; src_type_q <= 1'b0;
      dbuf <= '0; lnk_lo <= '0; desc_valid <= 1'b0; desc_side <= 1'b0;
      src_err <= 1'b0; dst_err <= 1'b0; err_flag <= 1'b0;
      src_ptr <= '0; dst_ptr <= '0;
    end else begin
      desc_valid <= 1'b0;
      src_err    <= 1'b0;
      dst_err    <= 1'b0;
      if (!busy) begin
        if (ld_ptrs) begin
          src_ptr  <= src_start;
          dst_ptr  <= dst_start;
          err_flag <= 1'b0;
        end else if ((pick_s || pick_d) && !mem_mode) begin
          desc_valid <= 1'b1;
          desc_side  <= pick_d;
          if (pick_s) dbuf <= {cfg_src_attr, cfg_src_size, {(64-AW){1'b0}}, cfg_src_addr};
          else        dbuf <= {2'b00, cfg_dst_attr, cfg_dst_size, {(64-AW){1'b0}}, cfg_dst_addr};
        end else if (pick_s || pick_d) begin
          desc_side <= pick_d;
          if (misal) begin
            dbuf       <= '0;
            desc_valid <= 1'b1;
            err_flag   <= 1'b1;
            src_err    <= pick_s;
            dst_err    <= pick_d;
            if (pick_s) src_type_q <= 1'b0;
            else        dst_ptr    <= dst_ptr + STEP;
          end else begin
            busy   <= 1'b1;
            op_dst <= pick_d;
            adv_q  <= 1'b0;
            wcnt   <= 3'd0;
          end
        end else if (pick_a) begin
          if (!src_type_q) src_ptr <= src_ptr + STEP;
          else begin
            busy   <= 1'b1;
            op_dst <= 1'b0;
            adv_q  <= 1'b1;
            wcnt   <= 3'd4;
          end
        end
      end else if (rd_valid) begin
        wcnt <= wcnt + 3'd1;
        case (wcnt)
          3'd0: dbuf[31:0]  <= rd_data;
          3'd1: dbuf[63:32] <= rd_data;
          3'd2: dbuf[64 +: SZW] <= rd_data[SZW-1:0];
          3'd3: begin
            dbuf[64+SZW +: 5] <= rd_data[4:0];
            if (!op_dst) begin
              busy       <= 1'b0;
              desc_valid <= 1'b1;
              src_type_q <= rd_data[1];
            end else if (!rd_data[1]) begin
              busy       <= 1'b0;
              desc_valid <= 1'b1;
              dst_ptr    <= dst_ptr + STEP;
            end
          end
          3'd4: lnk_lo <= rd_data;
          default: begin
            busy <= 1'b0;
            if (op_dst) begin
              dst_ptr    <= next_link;
              desc_valid <= !adv_q;
            end else begin
              src_ptr <= next_link;
            end
          end
        endcase
      end
    end
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R3
  src_fetch_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_side) |-> $stable(src_ptr));

  // R5
  dst_move_with_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_ptr != $past(dst_ptr)) |-> ((desc_valid && desc_side) || $past(ld_ptrs)));

  // R8
  err_zero_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_err || dst_err) |-> (desc_valid && desc_addr == '0 && desc_size == '0));

  // R8
  err_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (src_err || dst_err));
endmodule

// File: tb/dma_dscr_walker_bench.sv
`timescale 1ns/1ps
module dma_dscr_walker_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mem_mode = 1'b1, ld_ptrs = 1'b0;
  logic [48:0] src_start = '0, dst_start = '0;
  logic        fetch_src = 1'b0, fetch_dst = 1'b0, src_done = 1'b0;
  logic [48:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [29:0] cfg_src_size = '0, cfg_dst_size = '0;
  logic [4:0]  cfg_src_attr = '0;
  logic [2:0]  cfg_dst_attr = '0;
  logic        rd_req, rd_valid = 1'b0;
  logic [48:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        busy, desc_valid, desc_side, desc_coh, desc_type, desc_intr;
  logic [63:0] desc_addr;
  logic [29:0] desc_size;
  logic [1:0]  desc_cmd;
  logic        src_err, dst_err, err_flag;
  logic [48:0] src_ptr, dst_ptr;

  dma_dscr_walker u_dma_dscr_walker (
    .clk(clk), .rst_n(rst_n), .mem_mode(mem_mode), .ld_ptrs(ld_ptrs),
    .src_start(src_start), .dst_start(dst_start),
    .fetch_src(fetch_src), .fetch_dst(fetch_dst), .src_done(src_done),
    .cfg_src_addr(cfg_src_addr), .cfg_src_size(cfg_src_size), .cfg_src_attr(cfg_src_attr),
    .cfg_dst_addr(cfg_dst_addr), .cfg_dst_size(cfg_dst_size), .cfg_dst_attr(cfg_dst_attr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .desc_valid(desc_valid), .desc_side(desc_side),
    .desc_addr(desc_addr), .desc_size(desc_size), .desc_coh(desc_coh),
    .desc_type(desc_type), .desc_intr(desc_intr), .desc_cmd(desc_cmd),
    .src_err(src_err), .dst_err(dst_err), .err_flag(err_flag),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, ntr = 0, nval = 0, lat = 0;
  bit finished = 1'b0;
  logic [31:0] mem [0:255];
  logic [48:0] trace [0:15];
  logic        got_serr, got_derr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  function automatic logic [31:0] wd(input logic [48:0] p, input int k);
    logic [48:0] a;
    a = p + 49'(4 * k);
    return mem[a[9:2]];
  endfunction

  task automatic put_desc(input logic [48:0] p, input logic [63:0] ba, input logic [31:0] sz,
                          input logic [31:0] at, input logic [31:0] nlo, input logic [31:0] nhi);
    logic [31:0] w [0:5];
    w[0] = ba[31:0]; w[1] = ba[63:32]; w[2] = sz; w[3] = at; w[4] = nlo; w[5] = nhi;
    for (int k = 0; k < 6; k++) begin
      logic [48:0] a;
      a = p + 49'(4 * k);
      mem[a[9:2]] = w[k];
    end
  endtask

  function automatic logic [48:0] link_of(input logic [48:0] p);
    logic [31:0] hi;
    hi = wd(p, 5);
    return {hi[16:0], wd(p, 4)};
  endfunction

  always @(negedge clk) begin
    if (rd_req && !rd_valid) begin
      if (lat == 0) begin
        rd_valid = 1'b1;
        rd_data  = mem[rd_addr[9:2]];
        if (ntr < 16) trace[ntr] = rd_addr;
        ntr++;
        lat = $urandom % 3;
      end else lat--;
    end else rd_valid = 1'b0;
  end

  always @(negedge clk) if (desc_valid) nval++;

  task automatic load(input logic [48:0] s, input logic [48:0] d);
    @(negedge clk); ld_ptrs = 1'b1; src_start = s; dst_start = d;
    @(negedge clk); ld_ptrs = 1'b0;
  endtask

  task automatic do_fetch(input bit dst, input string tag);
    int n;
    n = 0;
    ntr = 0;
    @(negedge clk); if (dst) fetch_dst = 1'b1; else fetch_src = 1'b1;
    @(negedge clk); fetch_dst = 1'b0; fetch_src = 1'b0;
    while (!desc_valid && n < 1000) begin @(negedge clk); n++; end
    got_serr = src_err; got_derr = dst_err;
    chk(desc_valid == 1'b1, tag, 64'(n), 64'd0);
  endtask

  task automatic do_adv();
    ntr = 0;
    @(negedge clk); src_done = 1'b1;
    @(negedge clk); src_done = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic check_desc(input string tag, input logic [48:0] p, input bit dst);
    logic [31:0] a3;
    a3 = wd(p, 3);
    chk_eq({tag, " R2 addr"}, desc_addr, {wd(p, 1), wd(p, 0)});
    chk_eq({tag, " R2 size"}, 64'(desc_size), 64'(wd(p, 2) & 32'h3fff_ffff));
    chk_eq({tag, " R2 attr"}, {59'd0, desc_cmd, desc_intr, desc_type, desc_coh},
           {59'd0, (dst ? 2'b00 : a3[4:3]), a3[2:0]});
    chk_eq({tag, " side"}, 64'(desc_side), 64'(dst));
  endtask

  task automatic check_trace(input string tag, input logic [48:0] p, input int first, input int cnt);
    bit ok;
    ok = (ntr == cnt);
    for (int k = 0; k < cnt && k < 16; k++)
      if (trace[k] != p + 49'(4 * (first + k))) ok = 1'b0;
    chk(ok, tag, 64'(ntr), 64'(cnt));
  endtask

  initial begin
    int unused_seed;
    logic [48:0] p, q, sp;
    int v0;
    unused_seed = $urandom(32'h5eed_0017);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_eq("R1 src_ptr", 64'(src_ptr), 64'd0);
    chk_eq("R1 dst_ptr", 64'(dst_ptr), 64'd0);
    chk_eq("R1 flags", {61'd0, desc_valid, err_flag, rd_req}, 64'd0);
    rst_n = 1'b1;

    // R10 load
    load(49'h1_abcd_0000_0100, 49'h0_0042_0000_0200);
    chk_eq("R10 src load", 64'(src_ptr), 64'h1_abcd_0000_0100);
    chk_eq("R10 dst load", 64'(dst_ptr), 64'h0_0042_0000_0200);

    // R2 R3 linear source
    p = src_ptr;
    put_desc(p, 64'hdead_beef_0bad_f00d, 32'hffff_1234, 32'hffff_fff5, 32'h0, 32'h0);
    do_fetch(1'b0, "R2 src fetch");
    check_desc("R2 src linear", p, 1'b0);
    check_trace("R2 read order", p, 0, 4);
    chk_eq("R3 src ptr held", 64'(src_ptr), 64'(p));
    do_adv();
    chk_eq("R3 src linear step", 64'(src_ptr), 64'(p + 49'd16));

    // R4 linked source
    p = src_ptr;
    put_desc(p, 64'h1111_2222_3333_4444, 32'd77, 32'h0000_0002, 32'h0000_0340, 32'hfffe_0003);
    do_fetch(1'b0, "R4 src fetch");
    check_desc("R4 src linked", p, 1'b0);
    do_adv();
    chk_eq("R4 src link ptr", 64'(src_ptr), 64'(link_of(p)));
    check_trace("R4 link reads", p, 4, 2);

    // R5 R7 linear destination
    q = dst_ptr;
    put_desc(q, 64'h0123_4567_89ab_cdef, 32'd512, 32'h0000_001d, 32'h0, 32'h0);
    do_fetch(1'b1, "R5 dst fetch");
    check_desc("R7 dst cmd", q, 1'b1);
    chk_eq("R5 dst step", 64'(dst_ptr), 64'(q + 49'd16));

    // R6 linked destination
    q = dst_ptr;
    put_desc(q, 64'h5555_6666_7777_8888, 32'd9, 32'h0000_001b, 32'h0000_0080, 32'h0001_ffff);
    do_fetch(1'b1, "R6 dst fetch");
    check_desc("R6 dst linked", q, 1'b1);
    chk_eq("R6 dst link ptr", 64'(dst_ptr), 64'(link_of(q)));
    check_trace("R6 six reads", q, 0, 6);

    // random walks
    for (int it = 0; it < 40; it++) begin
      bit dst, typ;
      logic [31:0] at;
      dst = $urandom % 2;
      typ = $urandom % 2;
      at  = $urandom;
      at[1] = typ;
      p = dst ? dst_ptr : src_ptr;
      put_desc(p, {$urandom, $urandom}, $urandom, at, {$urandom, 4'b0} >> 4 << 4, $urandom);
      do_fetch(dst, "R2 random fetch");
      check_desc(dst ? "R6 random dst" : "R2 random src", p, dst);
      if (dst) begin
        chk_eq("R5 random dst next", 64'(dst_ptr), 64'(typ ? link_of(p) : p + 49'd16));
      end else begin
        do_adv();
        chk_eq("R4 random src next", 64'(src_ptr), 64'(typ ? link_of(p) : p + 49'd16));
      end
    end

    // R8 misaligned source and destination
    load(49'h0_0000_0000_0408, 49'h0_0000_0000_0204);
    do_fetch(1'b0, "R8 src misaligned");
    chk_eq("R8 src err strobe", {62'd0, got_serr, got_derr}, 64'd2);
    chk_eq("R8 zero desc", desc_addr | 64'(desc_size), 64'd0);
    chk_eq("R8 no reads", 64'(ntr), 64'd0);
    chk_eq("R8 err latched", 64'(err_flag), 64'd1);
    chk_eq("R8 src ptr held", 64'(src_ptr), 64'h408);
    do_adv();
    chk_eq("R8 src step after err", 64'(src_ptr), 64'h418);
    do_fetch(1'b1, "R8 dst misaligned");
    chk_eq("R8 dst err strobe", {62'd0, got_serr, got_derr}, 64'd1);
    chk_eq("R8 dst ptr step", 64'(dst_ptr), 64'h214);
    load(49'h0_0000_0000_0100, 49'h0_0000_0000_0300);
    chk_eq("R10 err cleared", 64'(err_flag), 64'd0);

    // R9 register mode
    mem_mode = 1'b0;
    cfg_src_addr = 49'h1_f0f0_1234_5678; cfg_src_size = 30'h2abc_def1; cfg_src_attr = 5'b10110;
    cfg_dst_addr = 49'h0_0abc_8765_4321; cfg_dst_size = 30'h0000_0040; cfg_dst_attr = 3'b101;
    do_fetch(1'b0, "R9 reg src");
    chk_eq("R9 reg src addr", desc_addr, 64'h1_f0f0_1234_5678);
    chk_eq("R9 reg src fields", {desc_size, desc_cmd, desc_intr, desc_type, desc_coh},
           {30'h2abc_def1, 5'b10110});
    chk_eq("R9 no reads", 64'(ntr), 64'd0);
    do_fetch(1'b1, "R9 reg dst");
    chk_eq("R9 reg dst fields", {desc_addr[48:0], desc_size, desc_cmd, desc_intr, desc_type, desc_coh},
           {49'h0_0abc_8765_4321, 30'h40, 2'b00, 3'b101});
    chk_eq("R9 ptrs kept", {15'd0, src_ptr}, 64'h100);
    do_adv();
    repeat (3) @(negedge clk);
    chk_eq("R9 src_done ignored", 64'(src_ptr), 64'h100);

    // R11 priority in register mode
    v0 = nval;
    @(negedge clk); fetch_src = 1'b1; fetch_dst = 1'b1;
    @(negedge clk); fetch_src = 1'b0; fetch_dst = 1'b0;
    chk_eq("R11 src wins", {62'd0, desc_valid, desc_side}, 64'd2);
    repeat (4) @(negedge clk);
    chk_eq("R11 dst dropped", 64'(nval - v0), 64'd1);

    // R11 requests during busy are dropped
    mem_mode = 1'b1;
    q = dst_ptr; sp = src_ptr;
    put_desc(q, 64'h9, 32'd3, 32'h0000_0002, 32'h0000_0500, 32'h0000_0001);
    v0 = nval; ntr = 0;
    @(negedge clk); fetch_dst = 1'b1;
    @(negedge clk); fetch_dst = 1'b0; fetch_src = 1'b1; src_done = 1'b1;
    @(negedge clk); fetch_src = 1'b0; src_done = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk_eq("R11 one valid", 64'(nval - v0), 64'd1);
    chk_eq("R11 six reads", 64'(ntr), 64'd6);
    chk_eq("R11 src untouched", 64'(src_ptr), 64'(sp));
    chk_eq("R6 dst link", 64'(dst_ptr), 64'(link_of(q)));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule